// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block keeps the configuration byte and the latched event flags of a cell-based serial line interface, and turns pending flags into an active-low interrupt request. A small register bus carries the traffic. It has an address, a read strobe, a write strobe, write data and combinational read data. The configuration byte sits at offset 0 and the event flags at offset 1. Each configuration bit is also driven straight out to the datapath as its own output.

The datapath reports events as one-cycle pulses:

- bad header checksum on a received cell
- truncated received cell
- transmit parity fault
- undefined line symbol
- receive buffer overflow

It also supplies a level that reports poor line quality. Each pulse latches a flag. The flag stays set until software reads the flag register. Any change of the quality level, in either direction, latches a flag of its own. Software can mask the interrupt entirely. It can also restrict the interrupt to the two received-cell error flags.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0x49. The outputs map to the configuration bits as follows: clock doubling on bit 7, drop errored cells on bit 6, cell-error-only interrupt on bit 5, parity check on bit 4, drop idle cells on bit 3, transmit halt on bit 2, byte mode on bit 1 (0 selects cell mode), interrupt enable on bit 0.
- R2: A write strobe at offset 0 loads all eight configuration bits at that clock edge. Reading offset 0 returns them.
- R3: Each event pulse sets its flag at the clock edge where the pulse is sampled. The flag positions are: header checksum error on bit 5, truncated cell on bit 4, transmit parity on bit 3, line symbol error on bit 1, overflow on bit 0. A set flag holds until it is cleared.
- R4: A read of offset 1 returns the flag byte as it stood before the read. At that edge the read clears bits 5..0. A flag whose event arrives in the same cycle as the clearing read stays set.
- R5: Bit 6 of the flag register shows the quality level live: 1 means bad, 0 means good. A read does not clear it.
- R6: Bit 2 of the flag register latches at the edge after the quality level changes, whether it goes good to bad or bad to good.
- R7: The transmit parity flag can be set only while configuration bit 4 is 1.
- R8: irq_n is driven low one clock after any of flag bits 5..0 is held with configuration bit 0 set. irq_n stays high while bit 0 is clear. Masking leaves the flags unchanged.
- R9: With configuration bits 0 and 5 both set, only flag bits 5 and 4 can pull irq_n low.
- R10: Writes to offset 1 and to unused offsets change nothing. Unused offsets and flag bit 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe (clears flags at offset 1) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| ev_hec_err | input | 1 | Header checksum error pulse |
| ev_short_cell | input | 1 | Truncated cell pulse |
| ev_tx_par_err | input | 1 | Transmit parity fault pulse |
| ev_sym_err | input | 1 | Undefined line symbol pulse |
| ev_rx_ovf | input | 1 | Receive buffer overflow pulse |
| sig_bad | input | 1 | Line quality level, 1 = bad |
| irq_n | output | 1 | Active-low interrupt request |
| cfg_clk_x2 | output | 1 | Configuration bit 7 |
| cfg_discard_err | output | 1 | Configuration bit 6 |
| cfg_err_only_irq | output | 1 | Configuration bit 5 |
| cfg_par_chk | output | 1 | Configuration bit 4 |
| cfg_discard_idle | output | 1 | Configuration bit 3 |
| cfg_tx_halt | output | 1 | Configuration bit 2 |
| cfg_byte_mode | output | 1 | Configuration bit 1 |
| cfg_irq_en | output | 1 | Configuration bit 0 |

## Verification
Read data is combinational, so a read value is due in the same cycle as its strobe. A flag or configuration write becomes visible one edge after the cycle in which its pulse or strobe is held. irq_n lags the flags by one further edge. The bench drives every input just after the falling edge and samples it shortly afterwards. A flag check therefore falls one driven cycle after the pulse, and an irq_n check two driven cycles after it. Read values pass through a scoreboard queue, which the monitor pops in the cycle of the strobe. That places each comparison before the clearing edge.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_EV  = 6;

    // Configuration byte, bit 7 first
    typedef struct packed {
        logic clk_x2;
        logic discard_err;
        logic err_only_irq;
        logic par_chk;
        logic discard_idle;
        logic tx_halt;
        logic byte_mode;
        logic irq_en;
    } ctrl_t;

    localparam logic [DATA_W-1:0] CTRL_RST = 8'h49;

    // Flag register bit positions
    localparam int ST_OVF      = 0;
    localparam int ST_SYM      = 1;
    localparam int ST_SIG_CHG  = 2;
    localparam int ST_TXPAR    = 3;
    localparam int ST_SHORT    = 4;
    localparam int ST_HEC      = 5;

    localparam int OFS_CTRL = 0;
    localparam int OFS_STAT = 1;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [NUM_EV-1:0] sticky,
        input logic              live_bad
    );
        return {1'b0, live_bad, sticky};
    endfunction

    function automatic logic cell_err_pending(input logic [NUM_EV-1:0] s);
        return s[ST_HEC] | s[ST_SHORT];
    endfunction

endpackage

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import irq_status_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = CTRL_RST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_o
);

    always_ff @(posedge clk) begin
        if (rst)        ctrl_o <= ctrl_t'(RST_VAL);
        else if (wr_en) ctrl_o <= ctrl_t'(wdata);
    end

    // R2
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ctrl_o == $past(ctrl_o));

endmodule

// File: rtl/sig_change_det.sv
module sig_change_det (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic chg_o
);

    logic prev_q;

    always_ff @(posedge clk) begin
        prev_q <= level_i;
    end

    assign chg_o = !rst && (prev_q != level_i);

endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] sticky_o
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)             sticky_o[b] <= 1'b0;
            else if (set_i[b])   sticky_o[b] <= 1'b1;
            else if (clr_i)      sticky_o[b] <= 1'b0;
        end
    end

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));

    // R4
    event_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((sticky_o & $past(set_i)) == $past(set_i)));

    // R4
    clear_done_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0) |=> sticky_o == '0);

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_status_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_hec_err,
    input  logic              ev_short_cell,
    input  logic              ev_tx_par_err,
    input  logic              ev_sym_err,
    input  logic              ev_rx_ovf,
    input  logic              sig_bad,
    output logic              irq_n,
    output logic              cfg_clk_x2,
    output logic              cfg_discard_err,
    output logic              cfg_err_only_irq,
    output logic              cfg_par_chk,
    output logic              cfg_discard_idle,
    output logic              cfg_tx_halt,
    output logic              cfg_byte_mode,
    output logic              cfg_irq_en
);

    ctrl_t             ctrl_q;
    logic              sel_ctrl, sel_stat;
    logic              sig_chg;
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] sticky;
    logic              irq_req;

    assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));

    ctrl_reg #(.RST_VAL(CTRL_RST)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (bus_wr && sel_ctrl),
        .wdata  (bus_wdata),
        .ctrl_o (ctrl_q)
    );

    sig_change_det u_sigdet (
        .clk     (clk),
        .rst     (rst),
        .level_i (sig_bad),
        .chg_o   (sig_chg)
    );

    always_comb begin
        ev_set             = '0;
        ev_set[ST_OVF]     = ev_rx_ovf;
        ev_set[ST_SYM]     = ev_sym_err;
        ev_set[ST_SIG_CHG] = sig_chg;
        ev_set[ST_TXPAR]   = ev_tx_par_err && ctrl_q.par_chk;
        ev_set[ST_SHORT]   = ev_short_cell;
        ev_set[ST_HEC]     = ev_hec_err;
    end

    sticky_bank #(.N(NUM_EV)) u_sticky (
        .clk      (clk),
        .rst      (rst),
        .set_i    (ev_set),
        .clr_i    (bus_rd && sel_stat),
        .sticky_o (sticky)
    );

    always_comb begin
        if (sel_ctrl)      bus_rdata = ctrl_q;
        else if (sel_stat) bus_rdata = pack_status(sticky, sig_bad);
        else               bus_rdata = '0;
    end

    assign irq_req = ctrl_q.irq_en &&
                     (ctrl_q.err_only_irq ? cell_err_pending(sticky) : (|sticky));

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= !irq_req;
    end

    assign cfg_clk_x2       = ctrl_q.clk_x2;
    assign cfg_discard_err  = ctrl_q.discard_err;
    assign cfg_err_only_irq = ctrl_q.err_only_irq;
    assign cfg_par_chk      = ctrl_q.par_chk;
    assign cfg_discard_idle = ctrl_q.discard_idle;
    assign cfg_tx_halt      = ctrl_q.tx_halt;
    assign cfg_byte_mode    = ctrl_q.byte_mode;
    assign cfg_irq_en       = ctrl_q.irq_en;

    // R6
    sig_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (sig_bad != $past(sig_bad)) |=> sticky[ST_SIG_CHG]);

    // R7
    parity_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_par_chk && !sticky[ST_TXPAR]) |=> !sticky[ST_TXPAR]);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_irq_en |=> irq_n);

    // R9
    cell_only_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_irq_en && cfg_err_only_irq && !sticky[ST_HEC] && !sticky[ST_SHORT]) |=> irq_n);

    // R10
    stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !sel_ctrl && !bus_rd && ev_set == '0) |=> sticky == $past(sticky));

endmodule

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic ev_hec_err = 0, ev_short_cell = 0, ev_tx_par_err = 0, ev_sym_err = 0, ev_rx_ovf = 0;
    logic sig_bad = 0;
    logic irq_n;
    logic cfg_clk_x2, cfg_discard_err, cfg_err_only_irq, cfg_par_chk;
    logic cfg_discard_idle, cfg_tx_halt, cfg_byte_mode, cfg_irq_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_hec_err(ev_hec_err), .ev_short_cell(ev_short_cell), .ev_tx_par_err(ev_tx_par_err),
        .ev_sym_err(ev_sym_err), .ev_rx_ovf(ev_rx_ovf), .sig_bad(sig_bad), .irq_n(irq_n),
        .cfg_clk_x2(cfg_clk_x2), .cfg_discard_err(cfg_discard_err),
        .cfg_err_only_irq(cfg_err_only_irq), .cfg_par_chk(cfg_par_chk),
        .cfg_discard_idle(cfg_discard_idle), .cfg_tx_halt(cfg_tx_halt),
        .cfg_byte_mode(cfg_byte_mode), .cfg_irq_en(cfg_irq_en)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        step();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    // driver: one read strobe, expected value pushed to the scoreboard
    task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        step();
        bus_addr = a; bus_rd = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        step();
        bus_rd = 1'b0;
    endtask

    // monitor: compares read data in the strobe cycle, before the clearing edge
    always @(negedge clk) begin
        #2;
        if (bus_rd) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard unexpected read actual=%02h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk(bus_rdata, it.exp, it.tag);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk({cfg_clk_x2, cfg_discard_err, cfg_err_only_irq, cfg_par_chk,
             cfg_discard_idle, cfg_tx_halt, cfg_byte_mode, cfg_irq_en}, 8'h49, "R1 cfg outputs");
        bus_read(2'd0, 8'h49, "R1 ctrl reset");
        bus_read(2'd1, 8'h00, "R1 status reset");
        chk({7'd0, irq_n}, 8'h01, "R8 irq idle");

        // R3 single event, R8 interrupt, R4 read clear
        step(); ev_hec_err = 1; step(); ev_hec_err = 0;
        step();
        chk({7'd0, irq_n}, 8'h00, "R8 irq asserted");
        bus_read(2'd1, 8'h20, "R3 hec flag");
        bus_read(2'd1, 8'h00, "R4 cleared by read");
        step();
        chk({7'd0, irq_n}, 8'h01, "R8 irq released");

        // R3 several events together
        step(); ev_short_cell = 1; ev_sym_err = 1; ev_rx_ovf = 1;
        step(); ev_short_cell = 0; ev_sym_err = 0; ev_rx_ovf = 0;
        bus_read(2'd1, 8'h13, "R3 multi flags");

        // R7 parity gating
        step(); ev_tx_par_err = 1; step(); ev_tx_par_err = 0;
        bus_read(2'd1, 8'h00, "R7 parity ignored when off");
        bus_write(2'd0, 8'h59);
        step(); ev_tx_par_err = 1; step(); ev_tx_par_err = 0;
        bus_read(2'd1, 8'h08, "R7 parity flag when on");

        // R5 live level, R6 both edges
        step(); sig_bad = 1'b1;
        step();
        bus_read(2'd1, 8'h44, "R6 rise latched, R5 live");
        bus_read(2'd1, 8'h40, "R5 live not cleared");
        step(); sig_bad = 1'b0;
        step();
        bus_read(2'd1, 8'h04, "R6 fall latched");

        // R4 event in same cycle as clearing read
        step();
        bus_addr = 2'd1; bus_rd = 1'b1; ev_rx_ovf = 1'b1;
        sb_q.push_back('{exp: 8'h00, tag: "R4 pre-clear value"});
        step();
        bus_rd = 1'b0; ev_rx_ovf = 1'b0;
        bus_read(2'd1, 8'h01, "R4 event survives clear");

        // R8 masked
        bus_write(2'd0, 8'h48);
        step(); ev_sym_err = 1; step(); ev_sym_err = 0;
        step();
        chk({7'd0, irq_n}, 8'h01, "R8 masked irq high");
        bus_read(2'd1, 8'h02, "R8 mask keeps flag");

        // R9 cell-error-only
        bus_write(2'd0, 8'h69);
        step(); ev_sym_err = 1; step(); ev_sym_err = 0;
        step();
        chk({7'd0, irq_n}, 8'h01, "R9 non-cell flag no irq");
        step(); ev_hec_err = 1; step(); ev_hec_err = 0;
        step();
        chk({7'd0, irq_n}, 8'h00, "R9 cell flag irq");
        bus_read(2'd1, 8'h22, "R9 flags");

        // R10 ignored writes
        bus_write(2'd1, 8'hFF);
        bus_read(2'd1, 8'h00, "R10 status write ignored");
        bus_write(2'd2, 8'hFF);
        bus_read(2'd0, 8'h69, "R10 unused write ignored");
        bus_read(2'd3, 8'h00, "R10 unused reads zero");

        // R2 write and output mapping
        bus_write(2'd0, 8'h86);
        chk({cfg_clk_x2, cfg_discard_err, cfg_err_only_irq, cfg_par_chk,
             cfg_discard_idle, cfg_tx_halt, cfg_byte_mode, cfg_irq_en}, 8'h86, "R2 cfg outputs");
        bus_read(2'd0, 8'h86, "R2 ctrl readback");

        repeat (3) step();
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule